// File: doc/BRIEF.md
# Four-Decade BCD Up/Down Counter with Compare

This block is a four-digit BCD counter. It steps once for each qualified rising edge on an asynchronous count input, upward or downward. It keeps a separate preset register and compares it with the count at all times. Three flags report on the count: an active-low zero flag, an active-low equal flag, and a one-clock carry/borrow pulse on wrap-around. A set of output latches follows the count while the store input is low and holds its value while store is high. This lets the displayed or exported value stay apart from the running count.

A load sequencer outside the block supplies digit strobes with a shared 4-bit data bus. Each strobe writes one digit of the counter or of the register. A mode input picks between two ranges. Decade mode runs to 9999. Timing mode runs to 5959, which suits a minutes:seconds display because both tens digits stop at 5. An active-low clear input zeroes the counter asynchronously. A separate synchronous active-low reset initialises the whole block.

Top module: `bcd_updown_compare`

## Requirements
- R1: A rising edge on `cnt_in` is synchronised and acted on at the third clock edge after it arrives. At that edge the counter adds one when `up_dn` is 1 and subtracts one when `up_dn` is 0; `up_dn` is sampled at that same edge.
- R2: Digit i occupies bits [4i+3:4i], with digit 0 the least significant. With `timing_mode`=0 every digit runs 0..9. With `timing_mode`=1, digits 1 and 3 run 0..5, so the maximum count is 5959 and, for example, 0059 steps up to 0100.
- R3: `carry_pulse` is high for exactly one clock, in the cycle after the step, when the count wraps from the maximum to 0000 going up or from 0000 to the maximum going down. It is 0 otherwise.
- R4: `zero_n` is 0 exactly while the counter holds 0000.
- R5: `equal_n` is 0 exactly while every counter digit equals the matching register digit.
- R6: `clr_n`=0 clears the counter to 0000 at once, without waiting for a clock, and leaves the register unchanged.
- R7: If a register strobe is active while `clr_n`=0, the strobed register digit is written with 0 instead of `ld_data`.
- R8: No count step and no carry pulse occurs while `clr_n`=0 or while any bit of `ld_cnt_stb` is 1.
- R9: While `store_n`=0, `latch_q` takes the counter value at each clock. While `store_n`=1, `latch_q` holds its value.
- R10: `ld_cnt_stb[i]`=1 writes `ld_data` into counter digit i at the clock edge, and `ld_reg_stb[i]`=1 writes it into register digit i.
- R11: `rst_n`=0 at a clock edge sets the counter, the register and `latch_q` to zero and `carry_pulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cnt_in | input | 1 | Asynchronous count input, rising edge counts |
| up_dn | input | 1 | Direction, 1 = up, 0 = down |
| clr_n | input | 1 | Asynchronous active-low counter clear |
| store_n | input | 1 | Active-low transparent control for output latches |
| timing_mode | input | 1 | 0 = decade (9999), 1 = timing (5959) |
| ld_cnt_stb | input | 4 | Per-digit counter load strobes |
| ld_reg_stb | input | 4 | Per-digit register load strobes |
| ld_data | input | 4 | BCD digit for the strobed loads |
| latch_q | output | 16 | Latched count, four BCD digits |
| carry_pulse | output | 1 | One-clock wrap pulse |
| zero_n | output | 1 | Low while count is 0000 |
| equal_n | output | 1 | Low while count equals register |

## Verification
A count pulse driven on a falling clock edge reaches the counter on the third rising edge. The carry pulse is visible from that edge until the next one, so the bench samples it on the falling edge just after the step and checks that it has dropped one cycle later. The zero and equal flags are combinational from the counter and register, so they are checked on the same falling edge as the step. The clear is asynchronous, so its effect on the zero flag is checked one time unit after clear is driven, before any clock. Loads and the store latch settle on the first rising edge, so the bench reads them on the following falling edge.

// File: rtl/bcdc_pkg.sv
// Shared types and helpers for the BCD up/down counter with compare.
// Assumes digits are 4-bit BCD and that timing mode limits odd digits to 5.
package bcdc_pkg;
    localparam int DIG_W = 4;
    typedef logic [DIG_W-1:0] bcd_t;

    // Highest legal value of digit idx under the selected mode.
    function automatic bcd_t digit_limit(input logic timing, input int idx);
        return (timing && (idx % 2 == 1)) ? bcd_t'(5) : bcd_t'(9);
    endfunction
endpackage

// File: rtl/cnt_edge_det.sv
// Brings an asynchronous level into the clock domain through a synchroniser
// chain and flags each rising edge for one clock.
// Assumes the input stays high and low for at least SYNC_STAGES+1 clocks each.
module cnt_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN = SYNC_STAGES + 1;
    logic [CHAIN-1:0] chain;

    // Shift the input through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN-2:0], async_in};
    end

    assign rise = chain[CHAIN-2] & ~chain[CHAIN-1];
endmodule

// File: rtl/bcd_digit.sv
// One BCD decade of the counter: loadable, steps up or down with wrap, and
// reports when the next step in the current direction would wrap.
// Assumes loads carry values no greater than lim.
module bcd_digit
    import bcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  bcd_t lim,
    input  logic up,
    input  logic step,
    input  logic ld,
    input  bcd_t ld_val,
    output bcd_t q,
    output logic at_end
);
    // Asynchronous clear, then synchronous reset, load and step.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      q <= '0;
        else if (!rst_n) q <= '0;
        else if (ld)     q <= ld_val;
        else if (step) begin
            if (up) q <= (q == lim) ? bcd_t'(0) : q + bcd_t'(1);
            else    q <= (q == '0)  ? lim       : q - bcd_t'(1);
        end
    end

    assign at_end = up ? (q == lim) : (q == '0);

    assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q <= lim);
endmodule

// File: rtl/bcd_updown_compare.sv
// Four-decade BCD up/down counter with a preset register compared against it,
// zero/equal flags, a wrap carry pulse and store-controlled output latches.
// Assumes loaded digits are legal for the selected mode and that mode only
// changes under reset.
module bcd_updown_compare
    import bcdc_pkg::*;
#(
    parameter int NDIG        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_in,
    input  logic              up_dn,
    input  logic              clr_n,
    input  logic              store_n,
    input  logic              timing_mode,
    input  logic [NDIG-1:0]   ld_cnt_stb,
    input  logic [NDIG-1:0]   ld_reg_stb,
    input  logic [DIG_W-1:0]  ld_data,
    output logic [NDIG*DIG_W-1:0] latch_q,
    output logic              carry_pulse,
    output logic              zero_n,
    output logic              equal_n
);
    localparam int W = NDIG * DIG_W;

    logic          cnt_rise;
    logic          cnt_go;
    logic [NDIG:0] ripple;
    logic [NDIG-1:0] at_end;
    logic [W-1:0]  cnt_all;
    logic [W-1:0]  reg_all;

    cnt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cnt_in),
        .rise     (cnt_rise)
    );

    // A detected edge counts only when neither clear nor a counter load is active.
    assign cnt_go    = cnt_rise & clr_n & ~(|ld_cnt_stb);
    assign ripple[0] = cnt_go;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        bcd_t lim_i;
        bcd_t reg_q;
        assign lim_i         = digit_limit(timing_mode, i);
        assign ripple[i+1]   = ripple[i] & at_end[i];

        bcd_digit u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_n  (clr_n),
            .lim    (lim_i),
            .up     (up_dn),
            .step   (ripple[i]),
            .ld     (ld_cnt_stb[i]),
            .ld_val (ld_data),
            .q      (cnt_all[i*DIG_W +: DIG_W]),
            .at_end (at_end[i])
        );

        // Preset register digit; a load during clear writes zero.
        always_ff @(posedge clk) begin
            if (!rst_n)             reg_q <= '0;
            else if (ld_reg_stb[i]) reg_q <= clr_n ? ld_data : bcd_t'(0);
        end
        assign reg_all[i*DIG_W +: DIG_W] = reg_q;
    end

    // One-clock pulse when the step rippled through every digit.
    always_ff @(posedge clk) begin
        if (!rst_n) carry_pulse <= 1'b0;
        else        carry_pulse <= ripple[NDIG];
    end

    // Output latches follow the counter while store_n is low.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (!store_n) latch_q <= cnt_all;
    end

    assign zero_n  = (cnt_all != '0);
    assign equal_n = (cnt_all != reg_all);

    assert_carry_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        carry_pulse |-> (cnt_all == '0 || cnt_all[DIG_W-1:0] == bcd_t'(9)));

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (cnt_all == '0));

    assert_no_count_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n || ld_cnt_stb != '0) |=> !carry_pulse);

    assert_store_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !store_n |=> (latch_q == $past(cnt_all)));

    assert_store_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        store_n |=> $stable(latch_q));
endmodule

// File: tb/bcd_updown_compare_test.sv
module bcd_updown_compare_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, cnt_in, up_dn, clr_n, store_n, timing_mode;
    logic [3:0]  ld_cnt_stb, ld_reg_stb, ld_data;
    logic [15:0] latch_q;
    logic        carry_pulse, zero_n, equal_n;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] m_cnt, m_reg;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_updown_compare uut (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .up_dn(up_dn), .clr_n(clr_n),
        .store_n(store_n), .timing_mode(timing_mode), .ld_cnt_stb(ld_cnt_stb),
        .ld_reg_stb(ld_reg_stb), .ld_data(ld_data), .latch_q(latch_q),
        .carry_pulse(carry_pulse), .zero_n(zero_n), .equal_n(equal_n)
    );

    function automatic int lim_of(bit tm, int i);
        return (tm && (i % 2 == 1)) ? 5 : 9;
    endfunction

    // Expected next count and wrap flag from the digit rules.
    function automatic logic [15:0] model_step(logic [15:0] v, bit up, bit tm, output bit wrap);
        logic [15:0] r = v;
        bit c = 1;
        for (int i = 0; i < 4; i++) begin
            if (c) begin
                int d = int'(r[i*4 +: 4]);
                int l = lim_of(tm, i);
                if (up) begin
                    if (d == l) d = 0; else begin d = d + 1; c = 0; end
                end else begin
                    if (d == 0) d = l; else begin d = d - 1; c = 0; end
                end
                r[i*4 +: 4] = 4'(d);
            end
        end
        wrap = c;
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_flags(string req);
        check({req, " zero_n R4"},  16'(zero_n),  16'(m_cnt != 0));
        check({req, " equal_n R5"}, 16'(equal_n), 16'(m_cnt != m_reg));
    endtask

    // Full count pulse; the step lands on the third rising edge (R1).
    task automatic pulse(bit up, bit counts, string req);
        bit wrap = 0;
        logic [15:0] nxt = m_cnt;
        if (counts) nxt = model_step(m_cnt, up, timing_mode, wrap);
        up_dn  = up;
        cnt_in = 1'b1;
        repeat (3) tick();
        m_cnt = nxt;
        check({req, " carry R3"}, 16'(carry_pulse), 16'(wrap));
        check_flags(req);
        tick();
        check({req, " carry one-cycle R3"}, 16'(carry_pulse), 16'(0));
        cnt_in = 1'b0;
        repeat (3) tick();
    endtask

    task automatic read_latch(string req);
        store_n = 1'b0;
        tick();
        store_n = 1'b1;
        check({req, " latch R9"}, latch_q, m_cnt);
    endtask

    task automatic load_cnt(int i, logic [3:0] d);
        ld_cnt_stb = 4'(1 << i);
        ld_data    = d;
        tick();
        ld_cnt_stb = '0;
        m_cnt[i*4 +: 4] = d;
    endtask

    task automatic load_reg(int i, logic [3:0] d);
        ld_reg_stb = 4'(1 << i);
        ld_data    = d;
        tick();
        ld_reg_stb = '0;
        m_reg[i*4 +: 4] = d;
    endtask

    task automatic set_cnt(logic [15:0] v);
        for (int i = 0; i < 4; i++) load_cnt(i, v[i*4 +: 4]);
    endtask

    task automatic do_reset(bit tm);
        rst_n = 1'b0;
        timing_mode = tm;
        repeat (4) tick();
        rst_n = 1'b1;
        m_cnt = '0;
        m_reg = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit lat;
        void'($urandom(32'd4242));
        rst_n = 0; cnt_in = 0; up_dn = 1; clr_n = 1; store_n = 1;
        timing_mode = 0; ld_cnt_stb = '0; ld_reg_stb = '0; ld_data = '0;
        @(negedge clk);
        store_n = 1'b0;
        do_reset(0);
        store_n = 1'b1;
        // R11: reset state
        check("reset latch R11", latch_q, 16'h0000);
        check("reset carry R11", 16'(carry_pulse), 16'(0));
        check_flags("reset R11");

        // R1/R3: down wrap and up wrap in decade mode
        pulse(0, 1, "down wrap R1");
        read_latch("down wrap R1");
        check("down wrap value R1", m_cnt, 16'h9999);
        pulse(1, 1, "up wrap R1");
        read_latch("up wrap R1");

        // R10: digit loads, then ripple across two digits
        set_cnt(16'h0099);
        read_latch("load counter R10");
        pulse(1, 1, "ripple R1");
        read_latch("ripple R1");

        // R5: register compare
        for (int i = 0; i < 4; i++) load_reg(i, m_cnt[i*4 +: 4]);
        check_flags("register match R5");
        load_reg(0, 4'd7);
        check_flags("register mismatch R5");

        // R9: latch holds with store high
        lat = 0;
        pulse(1, 1, "hold R9");
        check("hold R9", latch_q, 16'h0100);

        // R6: asynchronous clear, register kept
        clr_n = 1'b0;
        #1;
        check("async clear R6", 16'(zero_n), 16'(0));
        m_cnt = '0;
        // R8: counting inhibited while clear is low
        pulse(1, 0, "clear inhibit R8");
        clr_n = 1'b1;
        tick();
        set_cnt(m_reg);
        check_flags("register kept R6");

        // R7: register load during clear writes zero
        clr_n = 1'b0;
        ld_reg_stb = 4'hF;
        ld_data = 4'd3;
        tick();
        ld_reg_stb = '0;
        m_reg = '0;
        m_cnt = '0;
        clr_n = 1'b1;
        tick();
        check_flags("clear+reg load R7");

        // R8: count edge while a counter strobe is held
        set_cnt(16'h1234);
        ld_cnt_stb = 4'b1000;
        ld_data = 4'd1;
        pulse(1, 0, "load inhibit R8");
        ld_cnt_stb = '0;
        read_latch("load inhibit R8");

        // R2: timing mode boundaries
        do_reset(1);
        set_cnt(16'h0059);
        pulse(1, 1, "timing 0059 R2");
        read_latch("timing 0059 R2");
        check("timing tens R2", m_cnt, 16'h0100);
        set_cnt(16'h5959);
        pulse(1, 1, "timing top wrap R2");
        pulse(0, 1, "timing bottom wrap R2");
        read_latch("timing max R2");
        check("timing max value R2", m_cnt, 16'h5959);

        // Random mix in both modes
        for (int pass = 0; pass < 2; pass++) begin
            do_reset(pass[0]);
            for (int n = 0; n < 300; n++) begin
                int op = int'($urandom % 7);
                int di = int'($urandom % 4);
                logic [3:0] dv = 4'($urandom % (lim_of(timing_mode, di) + 1));
                case (op)
                    0, 1, 2: pulse(bit'($urandom % 2), 1, "random count R1");
                    3: begin load_cnt(di, dv); check_flags("random load R10"); end
                    4: begin load_reg(di, dv); check_flags("random reg R10"); end
                    5: read_latch("random store R9");
                    default: begin
                        for (int i = 0; i < 4; i++) load_reg(i, m_cnt[i*4 +: 4]);
                        check_flags("random equal R5");
                    end
                endcase
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule